// File: doc/BRIEF.md
# Atomic Set/Clear Pin Output Register

This block holds the data-out value that drives a peripheral's output pins. It presents three word registers on a simple memory-mapped slave port. One is a direct data register that is written and read normally. The other two are alias addresses that let software raise or lower chosen pins without first reading the register. A set-alias write drives to 1 each bit written as 1. A clear-alias write drives to 0 each bit written as 1. Bits written as 0 keep their value in both cases.

Software in a multitasking system can therefore change its own pins with one store. There is no window in which another task's update could be lost. Both alias addresses read back the live register value, and byte strobes limit every kind of write to the enabled lanes. The reset input is asserted asynchronously and released synchronously inside the block.

Top module: `pin_setclr_reg`

## Requirements
- R1: While reset is asserted, and after it is released until the first write, every bit of `pin_out` is 0 and a read of offset 0x54 returns 0.
- R2: A write to offset 0x54 replaces each enabled byte of the register with the matching byte of `wr_data`, and a read of 0x54 returns the register value.
- R3: A write to offset 0x58 sets to 1 every register bit whose `wr_data` bit is 1 in an enabled lane. Bits whose `wr_data` bit is 0 keep their value.
- R4: A write to offset 0x5C clears to 0 every register bit whose `wr_data` bit is 1 in an enabled lane. Bits whose `wr_data` bit is 0 keep their value.
- R5: A read of offset 0x58 or offset 0x5C returns the current register value.
- R6: Strobe bit i enables byte lane `wr_data[8i+7:8i]`. Under any write, a lane whose strobe is 0 keeps its value.
- R7: A write appears on `pin_out` at the clock edge that ends the write cycle, and a read in the next cycle returns the new value. A read in the same cycle as a write returns the value from before the write.
- R8: `rd_data` is 0 when `rd_en` is low or the offset is not one of the three decoded offsets. A write to an undecoded offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Byte offset of the access |
| wr_en | input | 1 | Write strobe for this cycle |
| wr_strb | input | 4 | Byte lane enables for the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe for this cycle |
| rd_data | output | 32 | Read data, combinational from the register |
| pin_out | output | 32 | Registered data-out vector to the pins |

## Verification
The bench builds the block with its default values: 32 data bits, 4 byte lanes and an 8-bit offset. At that width every strobe pattern from 0 to 15 can be hit, and each of the three decoded offsets sits next to undecoded neighbours such as 0x50, 0x55 and 0x60. Directed sequences stack a set and a clear on the same bits and read in the same cycle as a write. Random traffic is then checked against a behavioural model every cycle, which covers all lane and offset combinations.

// File: rtl/psr_pkg.sv
package psr_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LOAD = 2'd1,
    OP_SET  = 2'd2,
    OP_CLR  = 2'd3
  } psr_op_e;
endpackage

// File: rtl/psr_rst_sync.sv
module psr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/psr_decode.sv
module psr_decode
  import psr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFS_DIRECT = 8'h54,
  parameter logic [ADDR_W-1:0] OFS_SET    = 8'h58,
  parameter logic [ADDR_W-1:0] OFS_CLR    = 8'h5C
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  output psr_op_e           op,
  output logic              rd_hit
);
  logic sel_direct, sel_set, sel_clr;

  always_comb begin
    sel_direct = (addr == OFS_DIRECT);
    sel_set    = (addr == OFS_SET);
    sel_clr    = (addr == OFS_CLR);
    op = OP_NONE;
    if (wr_en) begin
      if (sel_direct)   op = OP_LOAD;
      else if (sel_set) op = OP_SET;
      else if (sel_clr) op = OP_CLR;
    end
    rd_hit = rd_en && (sel_direct || sel_set || sel_clr);
  end
endmodule

// File: rtl/psr_lane.sv
module psr_lane
  import psr_pkg::*;
#(
  parameter int unsigned LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  psr_op_e           op,
  input  logic              lane_en,
  input  logic [LANE_W-1:0] wd,
  output logic [LANE_W-1:0] q
);
  logic [LANE_W-1:0] q_r, q_nxt;
  logic              upd;

  always_comb begin
    upd   = lane_en && (op != OP_NONE);
    q_nxt = q_r;
    case (op)
      OP_LOAD: q_nxt = wd;
      OP_SET:  q_nxt = q_r | wd;
      OP_CLR:  q_nxt = q_r & ~wd;
      default: q_nxt = q_r;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_r <= '0;
    else if (upd) q_r <= q_nxt;
  end

  assign q = q_r;

  p_load_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_en && op == OP_LOAD) |=> (q == $past(wd)));
  p_set_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_en && op == OP_SET) |=> ((q & $past(wd)) == $past(wd)) &&
                                  ((q & ~$past(wd)) == ($past(q) & ~$past(wd))));
  p_clr_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_en && op == OP_CLR) |=> ((q & $past(wd)) == '0) &&
                                  ((q & ~$past(wd)) == ($past(q) & ~$past(wd))));
  p_lane_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!lane_en || op == OP_NONE) |=> $stable(q));
endmodule

// File: rtl/psr_rdmux.sv
module psr_rdmux #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              rd_hit,
  input  logic [DATA_W-1:0] reg_val,
  output logic [DATA_W-1:0] rd_data
);
  always_comb begin
    rd_data = '0;
    if (rd_hit) rd_data = reg_val;
  end
endmodule

// File: rtl/pin_setclr_reg.sv
module pin_setclr_reg
  import psr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFS_DIRECT = 8'h54,
  parameter logic [ADDR_W-1:0] OFS_SET    = 8'h58,
  parameter logic [ADDR_W-1:0] OFS_CLR    = 8'h5C,
  localparam int unsigned LANE_W = 8,
  localparam int unsigned STRB_W = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [STRB_W-1:0] wr_strb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] pin_out
);
  logic    rst_sync_n;
  psr_op_e op;
  logic    rd_hit;
  logic [DATA_W-1:0] reg_val;

  psr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  psr_decode #(
    .ADDR_W     (ADDR_W),
    .OFS_DIRECT (OFS_DIRECT),
    .OFS_SET    (OFS_SET),
    .OFS_CLR    (OFS_CLR)
  ) u_dec (
    .addr   (addr),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .op     (op),
    .rd_hit (rd_hit)
  );

  for (genvar g = 0; g < STRB_W; g++) begin : g_lane
    psr_lane #(.LANE_W(LANE_W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .op      (op),
      .lane_en (wr_strb[g]),
      .wd      (wr_data[g*LANE_W +: LANE_W]),
      .q       (reg_val[g*LANE_W +: LANE_W])
    );
  end

  psr_rdmux #(.DATA_W(DATA_W)) u_rd (
    .rd_hit  (rd_hit),
    .reg_val (reg_val),
    .rd_data (rd_data)
  );

  assign pin_out = reg_val;

  p_alias_read_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en && (addr == OFS_SET || addr == OFS_CLR)) |-> (rd_data == pin_out));
  p_undecoded_read_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!rd_en || (addr != OFS_DIRECT && addr != OFS_SET && addr != OFS_CLR))
      |-> (rd_data == '0));
  p_undecoded_write_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!wr_en || (addr != OFS_DIRECT && addr != OFS_SET && addr != OFS_CLR))
      |=> $stable(pin_out));
  p_reset_zero_r1: assert property (@(posedge clk)
    (!rst_sync_n) |-> (pin_out == '0));
endmodule

// File: tb/test_pin_setclr_reg.sv
`timescale 1ns/1ps
module test_pin_setclr_reg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  addr;
  logic        wr_en;
  logic [3:0]  wr_strb;
  logic [31:0] wr_data;
  logic        rd_en;
  logic [31:0] rd_data;
  logic [31:0] pin_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [31:0] model = '0;
  string last_tag = "R1";

  always #2.5 clk = ~clk;

  pin_setclr_reg i_pin_setclr_reg (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_strb(wr_strb),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .pin_out(pin_out)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic bit decoded(input logic [7:0] a);
    return a == 8'h54 || a == 8'h58 || a == 8'h5C;
  endfunction

  task automatic cycle(input logic rd, input logic wr, input logic [7:0] a,
                       input logic [3:0] s, input logic [31:0] d);
    logic [31:0] exp_rd;
    string rtag;
    @(negedge clk);
    check(pin_out === model, last_tag, pin_out, model);
    rd_en = rd; wr_en = wr; addr = a; wr_strb = s; wr_data = d;
    #1;
    exp_rd = (rd && decoded(a)) ? model : 32'h0;
    if (!rd || !decoded(a)) rtag = "R8";
    else if (a == 8'h54)    rtag = "R2";
    else                    rtag = "R5";
    if (wr && rd && decoded(a)) rtag = "R7";
    check(rd_data === exp_rd, rtag, rd_data, exp_rd);
    @(posedge clk);
    if (wr && decoded(a)) begin
      for (int b = 0; b < 4; b++) begin
        if (s[b]) begin
          if (a == 8'h54)      model[b*8 +: 8] = d[b*8 +: 8];
          else if (a == 8'h58) model[b*8 +: 8] = model[b*8 +: 8] | d[b*8 +: 8];
          else                 model[b*8 +: 8] = model[b*8 +: 8] & ~d[b*8 +: 8];
        end
      end
      if (s != 4'hF)       last_tag = "R6";
      else if (a == 8'h54) last_tag = "R2";
      else if (a == 8'h58) last_tag = "R3";
      else                 last_tag = "R4";
    end else if (wr) begin
      last_tag = "R8";
    end else begin
      last_tag = "R7";
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr = '0; wr_en = 0; wr_strb = '0; wr_data = '0; rd_en = 0;
    repeat (3) @(negedge clk);
    check(pin_out === 32'h0, "R1", pin_out, 32'h0);
    rd_en = 1; addr = 8'h54; #1;
    check(rd_data === 32'h0, "R1", rd_data, 32'h0);
    rd_en = 0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(pin_out === 32'h0, "R1", pin_out, 32'h0);
    // R2 direct load, then readback
    cycle(0, 1, 8'h54, 4'hF, 32'hA5A5_0F0F);
    cycle(1, 0, 8'h54, 4'h0, 32'h0);
    // R3 set alias, R5 readback of set alias
    cycle(0, 1, 8'h58, 4'hF, 32'h0000_F000);
    cycle(1, 0, 8'h58, 4'h0, 32'h0);
    // R4 clear alias, R5 readback of clear alias
    cycle(0, 1, 8'h5C, 4'hF, 32'hA000_000F);
    cycle(1, 0, 8'h5C, 4'h0, 32'h0);
    // R6 strobes restrict each kind of write
    cycle(0, 1, 8'h58, 4'b0101, 32'hFFFF_FFFF);
    cycle(0, 1, 8'h5C, 4'b0010, 32'hFFFF_FFFF);
    cycle(0, 1, 8'h54, 4'b1000, 32'h1234_5678);
    cycle(0, 1, 8'h54, 4'b0000, 32'hFFFF_FFFF);
    cycle(1, 0, 8'h54, 4'h0, 32'h0);
    // R7 read during a write sees the old value, next read sees the new one
    cycle(1, 1, 8'h58, 4'hF, 32'h0000_00F0);
    cycle(1, 0, 8'h58, 4'h0, 32'h0);
    cycle(1, 1, 8'h5C, 4'hF, 32'hFFFF_FFFF);
    cycle(1, 0, 8'h5C, 4'h0, 32'h0);
    // R8 undecoded writes and reads
    cycle(0, 1, 8'h54, 4'hF, 32'hCAFE_BABE);
    cycle(1, 1, 8'h50, 4'hF, 32'h0);
    cycle(1, 1, 8'h55, 4'hF, 32'hFFFF_FFFF);
    cycle(1, 1, 8'h60, 4'hF, 32'h0);
    cycle(0, 0, 8'h54, 4'h0, 32'h0);
    cycle(1, 0, 8'h5D, 4'h0, 32'h0);
    // random traffic against the model
    for (int i = 0; i < 2000; i++) begin
      logic [7:0] a;
      case ($urandom_range(0, 4))
        0: a = 8'h54;
        1: a = 8'h58;
        2: a = 8'h5C;
        3: a = 8'h58;
        default: a = 8'($urandom_range(0, 255));
      endcase
      cycle(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a,
            4'($urandom_range(0, 15)), $urandom());
    end
    @(negedge clk);
    check(pin_out === model, last_tag, pin_out, model);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule